// File: doc/BRIEF.md
# Paged MDIO-to-32-bit register bridge

This bridge gives a management host that speaks only 16-bit MDIO register accesses a way into a 32-bit internal register space. The MDIO frame decoder sits in front of it and hands over one decoded access per strobe: PHY address, register number, write data and a direction bit. The bridge turns these accesses into single-cycle 32-bit requests on a simple internal register bus.

A 9-bit page register, reached at PHY 0x1F register 0x10, supplies word-address bits [15:7]. Eight pseudo-PHYs, 0x10 to 0x17, choose word-address bits [6:4]. Within one of these PHYs, register bits [4:1] give word-address bits [3:0], and register bit 0 picks the half: even is data [15:0] and odd is data [31:16]. The host writes the high half first and the low half second, and it reads the low half first and the high half second. The bridge relies on that order to make each 32-bit access atomic. A high-half write is staged and goes out only together with the low-half write. A low-half read fetches all 32 bits and keeps the upper half for the read that follows.

Top module: `mdio_page_bridge`

## Requirements
- R1: A write to PHY 0x1F register 0x10 loads mdio_wdata[8:0] into the page register. A read of that register returns the page zero-extended to 16 bits.
- R2: A window access (PHY 0x10 to 0x17) presents reg_addr = {page[8:0], phy[2:0], reg[4:1]}.
- R3: A write to an odd window register stores mdio_wdata in the high-half staging register. It raises no bus request.
- R4: A write to an even window register raises reg_req with reg_we=1 in the strobe cycle, with reg_wdata = {staged high half, mdio_wdata}.
- R5: A read of an even window register raises reg_req with reg_we=0 in the strobe cycle. It returns reg_rdata[15:0] and latches reg_rdata[31:16].
- R6: A read of an odd window register raises no bus request. It returns the latched high half, so a low/high read pair comes from one 32-bit read even if the register changes in between.
- R7: An access to any other PHY, or to PHY 0x1F at a register other than 0x10, raises no bus request and leaves the page and the staged half unchanged. A read there returns 0xFFFF.
- R8: After reset the page is 0, the staged and latched halves are 0, and mdio_rvalid is 0.
- R9: mdio_rvalid is high for exactly the one cycle after each read strobe, with mdio_rdata valid in that cycle. It is never high after a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mdio_valid | input | 1 | Strobe for one decoded MDIO access |
| mdio_write | input | 1 | 1 = write, 0 = read |
| mdio_phy | input | 5 | PHY address of the access |
| mdio_reg | input | 5 | Register number of the access |
| mdio_wdata | input | 16 | Write data |
| mdio_rvalid | output | 1 | Read data valid |
| mdio_rdata | output | 16 | Read data |
| reg_req | output | 1 | Internal bus request |
| reg_we | output | 1 | Internal bus write enable |
| reg_addr | output | 16 | Internal word address |
| reg_wdata | output | 32 | Internal write data |
| reg_rdata | input | 32 | Internal read data, valid in the request cycle |

## Verification
The internal bus request, address and write data depend combinationally on the strobe, so the bench samples them in the strobe cycle, one time unit after it drives the inputs. Read data and mdio_rvalid are registered and are due one edge later, so the bench samples them at the falling edge after that rising edge. Page, staging and latch updates take effect from the next access onward. The bench's model applies them only after it has checked the current access, and it changes the register contents between a low-half read and a high-half read to show the latch at work.

// File: rtl/mpw_pkg.sv
package mpw_pkg;
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_PAGE = 2'd1,
        KIND_WIN  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      hi_half;
    } acc_dec_t;

    function automatic logic in_window(input logic [PHY_W-1:0] phy,
                                       input logic [PHY_W-1:0] base,
                                       input int sel_w);
        logic hit;
        hit = 1'b1;
        for (int i = 0; i < PHY_W; i++)
            if (i >= sel_w && phy[i] != base[i]) hit = 1'b0;
        return hit;
    endfunction
endpackage

// File: rtl/mpw_decode.sv
module mpw_decode
    import mpw_pkg::*;
#(
    parameter int             WIN_SEL_W = 3,
    parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
    parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
    parameter logic [PHY_W-1:0] WIN_BASE = 5'h10
) (
    input  logic [PHY_W-1:0] phy,
    input  logic [REG_W-1:0] regn,
    output acc_dec_t         dec
);
    always_comb begin
        dec.hi_half = regn[0];
        if (phy == PAGE_PHY && regn == PAGE_REG)
            dec.kind = KIND_PAGE;
        else if (in_window(phy, WIN_BASE, WIN_SEL_W))
            dec.kind = KIND_WIN;
        else
            dec.kind = KIND_NONE;
    end
endmodule

// File: rtl/mpw_page_reg.sv
module mpw_page_reg #(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] din,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst)       page <= '0;
        else if (load) page <= din;
    end

    // R1, R7: page moves only on a page-register write
    a_r1_page_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(page));
endmodule

// File: rtl/mpw_halves.sv
module mpw_halves
    import mpw_pkg::*;
#(
    parameter int PAGE_W = 9,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              write,
    input  acc_dec_t          dec,
    input  logic [ADDR_W-1:0] win_addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [PAGE_W-1:0] page,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              rsp_valid,
    output logic [HALF_W-1:0] rsp_data
);
    logic [HALF_W-1:0] staged_hi;
    logic [HALF_W-1:0] latched_hi;
    logic [HALF_W-1:0] rsp_next;
    logic              win_acc;
    logic              stage_we;
    logic              bus_rd;

    assign win_acc   = valid && (dec.kind == KIND_WIN);
    assign stage_we  = win_acc && write && dec.hi_half;
    assign bus_req   = win_acc && !dec.hi_half;
    assign bus_we    = write;
    assign bus_addr  = win_addr;
    assign bus_wdata = {staged_hi, wdata};
    assign bus_rd    = bus_req && !write;

    always_comb begin
        case (dec.kind)
            KIND_PAGE: rsp_next = {{(HALF_W-PAGE_W){1'b0}}, page};
            KIND_WIN:  rsp_next = dec.hi_half ? latched_hi : bus_rdata[HALF_W-1:0];
            default:   rsp_next = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_hi  <= '0;
            latched_hi <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
        end else begin
            if (stage_we) staged_hi  <= wdata;
            if (bus_rd)   latched_hi <= bus_rdata[WORD_W-1:HALF_W];
            rsp_valid <= valid && !write;
            if (valid && !write) rsp_data <= rsp_next;
        end
    end

    // R3: staging register changes only on a high-half window write
    a_r3_stage_hold: assert property (@(posedge clk) disable iff (rst)
        !stage_we |=> $stable(staged_hi));
    // R6: latched half changes only on an internal read
    a_r6_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(latched_hi));
    // R9: response follows each read by one cycle
    a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        (valid && !write) |=> rsp_valid);
    // R9: no response without a read
    a_r9_no_rsp_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(valid && !write) |=> !rsp_valid);
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mpw_pkg::*;
#(
    parameter int             PAGE_W    = 9,
    parameter int             WIN_SEL_W = 3,
    parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
    parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
    parameter logic [PHY_W-1:0] WIN_BASE = 5'h10,
    localparam int            ADDR_W    = PAGE_W + WIN_SEL_W + REG_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdio_valid,
    input  logic              mdio_write,
    input  logic [PHY_W-1:0]  mdio_phy,
    input  logic [REG_W-1:0]  mdio_reg,
    input  logic [HALF_W-1:0] mdio_wdata,
    output logic              mdio_rvalid,
    output logic [HALF_W-1:0] mdio_rdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata
);
    acc_dec_t          dec;
    logic [PAGE_W-1:0] page;
    logic              page_load;
    logic [ADDR_W-1:0] win_addr;

    mpw_decode #(
        .WIN_SEL_W(WIN_SEL_W), .PAGE_PHY(PAGE_PHY),
        .PAGE_REG(PAGE_REG), .WIN_BASE(WIN_BASE)
    ) u_dec (
        .phy(mdio_phy), .regn(mdio_reg), .dec(dec)
    );

    assign page_load = mdio_valid && mdio_write && (dec.kind == KIND_PAGE);

    mpw_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk(clk), .rst(rst), .load(page_load),
        .din(mdio_wdata[PAGE_W-1:0]), .page(page)
    );

    assign win_addr = {page, mdio_phy[WIN_SEL_W-1:0], mdio_reg[REG_W-1:1]};

    mpw_halves #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_halves (
        .clk(clk), .rst(rst), .valid(mdio_valid), .write(mdio_write),
        .dec(dec), .win_addr(win_addr), .wdata(mdio_wdata), .page(page),
        .bus_rdata(reg_rdata), .bus_req(reg_req), .bus_we(reg_we),
        .bus_addr(reg_addr), .bus_wdata(reg_wdata),
        .rsp_valid(mdio_rvalid), .rsp_data(mdio_rdata)
    );

    // R7: accesses outside page register and window never reach the bus
    a_r7_outside_quiet: assert property (@(posedge clk) disable iff (rst)
        (mdio_valid && dec.kind == KIND_NONE) |-> !reg_req);
    // R3: high-half writes never reach the bus
    a_r3_odd_write_no_bus: assert property (@(posedge clk) disable iff (rst)
        (mdio_valid && mdio_write && mdio_reg[0]) |-> !reg_req);
endmodule

// File: tb/sim_mdio_page_bridge.sv
module sim_mdio_page_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdio_valid = 1'b0, mdio_write = 1'b0;
    logic [4:0]  mdio_phy = '0, mdio_reg = '0;
    logic [15:0] mdio_wdata = '0;
    logic        mdio_rvalid;
    logic [15:0] mdio_rdata;
    logic        reg_req, reg_we;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [31:0] salt = 32'h1357_9BDF;

    int checks = 0, fails = 0;
    logic [8:0]  m_page = '0;
    logic [15:0] m_staged = '0, m_hi = '0;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] mem_fn(input logic [15:0] a, input logic [31:0] s);
        return {a ^ s[31:16], (~a) + s[15:0]};
    endfunction

    always_comb reg_rdata = mem_fn(reg_addr, salt);

    mdio_page_bridge u0 (
        .clk(clk), .rst(rst), .mdio_valid(mdio_valid), .mdio_write(mdio_write),
        .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
        .mdio_rvalid(mdio_rvalid), .mdio_rdata(mdio_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int kind_of(input logic [4:0] p, input logic [4:0] r);
        if (p == 5'h1F && r == 5'h10) return 1;
        if (p[4:3] == 2'b10) return 2;
        return 0;
    endfunction

    // one access: called at a falling edge, returns at the next falling edge
    task automatic access(input bit wr, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        int k;
        bit exp_req;
        logic [15:0] exp_addr, exp_rd;
        logic [31:0] word;
        k = kind_of(p, r);
        mdio_valid = 1'b1; mdio_write = wr; mdio_phy = p; mdio_reg = r; mdio_wdata = d;
        #1;
        exp_req  = (k == 2) && !r[0];
        exp_addr = {m_page, p[2:0], r[4:1]};
        word     = mem_fn(exp_addr, salt);
        chk(reg_req == exp_req, (k == 0) ? "R7 no bus" : (r[0] ? "R3/R6 no bus" : "R4/R5 req"),
            32'(reg_req), 32'(exp_req));
        if (exp_req) begin
            chk(reg_addr == exp_addr, "R2 addr", 32'(reg_addr), 32'(exp_addr));
            chk(reg_we == wr, wr ? "R4 we" : "R5 we", 32'(reg_we), 32'(wr));
            if (wr) chk(reg_wdata == {m_staged, d}, "R4 wdata", reg_wdata, {m_staged, d});
        end
        case (k)
            1: exp_rd = {7'b0, m_page};
            2: exp_rd = r[0] ? m_hi : word[15:0];
            default: exp_rd = 16'hFFFF;
        endcase
        @(posedge clk);
        @(negedge clk);
        mdio_valid = 1'b0;
        chk(mdio_rvalid == !wr, "R9 rvalid", 32'(mdio_rvalid), 32'(!wr));
        if (!wr)
            chk(mdio_rdata == exp_rd,
                (k == 1) ? "R1 page read" : (k == 0) ? "R7 ones" : (r[0] ? "R6 hi read" : "R5 lo read"),
                32'(mdio_rdata), 32'(exp_rd));
        if (k == 1 && wr) m_page = d[8:0];
        if (k == 2 && wr && r[0]) m_staged = d;
        if (k == 2 && !wr && !r[0]) m_hi = word[31:16];
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [4:0] p, r;
        int sel;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        chk(mdio_rvalid == 1'b0, "R8 rvalid", 32'(mdio_rvalid), 0);
        access(1'b0, 5'h1F, 5'h10, 16'h0);          // R8 page reads 0
        access(1'b0, 5'h13, 5'h05, 16'h0);          // R8 latched hi is 0
        // R1/R2 page then a paired write
        access(1'b1, 5'h1F, 5'h10, 16'hFEAB);
        access(1'b0, 5'h1F, 5'h10, 16'h0);
        access(1'b1, 5'h15, 5'h0B, 16'hCAFE);       // R3 stage
        access(1'b1, 5'h15, 5'h0A, 16'hBEEF);       // R4 commit
        // R7: outside accesses leave page and stage intact
        access(1'b1, 5'h1F, 5'h11, 16'h0055);
        access(1'b1, 5'h08, 5'h01, 16'h1234);
        access(1'b0, 5'h18, 5'h02, 16'h0);
        access(1'b0, 5'h00, 5'h10, 16'h0);
        access(1'b1, 5'h10, 5'h00, 16'h7777);       // staged still CAFE
        access(1'b0, 5'h1F, 5'h10, 16'h0);
        // R6: atomic pair across a register change
        access(1'b0, 5'h17, 5'h1E, 16'h0);
        salt = 32'hA5A5_0F0F;
        access(1'b0, 5'h17, 5'h1F, 16'h0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            sel = $urandom_range(0, 9);
            r = 5'($urandom);
            if (sel < 6)       p = {2'b10, 3'($urandom)};
            else if (sel == 6) begin p = 5'h1F; r = 5'h10; end
            else if (sel == 7) begin p = 5'h1F; if (r == 5'h10) r = 5'h00; end
            else begin
                p = 5'($urandom);
                if (p[4:3] == 2'b10) p[3] = 1'b1;
                if (p == 5'h1F && r == 5'h10) r = 5'h11;
            end
            if ((i % 37) == 0) salt = $urandom;
            access(1'($urandom), p, r, 16'($urandom));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule